// File: doc/BRIEF.md
# Write-Protection Command Sequence Detector

This block sits in the write path of a byte-wide non-volatile memory. It sees every qualified write cycle, which is an address and a data byte presented together for one clock with a valid strobe. For each write it decides in the same cycle whether the write may reach the array. It holds a protection flag. While the flag is set, ordinary writes are refused unless a short command sequence has just opened a page-load window.

Two fixed command sequences are recognised. The three-write unlock sequence turns protection on, whatever its previous state, and opens a window for up to one page of data bytes. The six-write disable sequence turns protection off. Command writes are consumed by the detector and never reach the array. A page load ends when the surrounding write-timing logic raises `load_end`. The block then re-locks and pulses `lock_done`. The reset value of the flag comes from a pin, which stands in for the stored non-volatile state.

Top module: `wp_cmd_guard`

## Requirements
- R1: During and after reset, `prot_on` equals `prot_init`, `win_open` is 0 and the matcher is idle.
- R2: While `prot_on` is 0, every valid write that is not consumed as a command step gives `wr_permit`=1 in the same cycle.
- R3: Three consecutive valid writes, data 0xAA to address 0x1555, then 0x55 to 0x0AAA, then 0xA0 to 0x1555, set `prot_on`=1 and `win_open`=1 from the cycle after the third write. This holds whether protection was on or off before.
- R4: A write that the matcher consumes as a command step (first step 0xAA@0x1555, or any later step that matches) always gives `wr_permit`=0.
- R5: While `prot_on` is 1 and no window is open, every valid write gives `wr_permit`=0.
- R6: While the window is open, the matcher ignores writes. The first PAGE_BYTES valid writes are permitted, and any further write is refused until the window closes.
- R7: When `load_end` is 1 while the window is open, `lock_done` is 1 in that cycle, `win_open` is 0 from the next cycle and `prot_on` stays 1. When the window is closed, `load_end` has no effect and `lock_done` stays 0.
- R8: Six consecutive writes, 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555, clear `prot_on` from the cycle after the sixth write.
- R9: A write that does not match the next expected step returns the matcher to idle, and that write is refused while protected. If the breaking write is itself 0xAA@0x1555, it starts a new sequence. Cycles with `wr_valid`=0 do not affect the matcher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_init | input | 1 | Value loaded into the protection flag at reset |
| wr_valid | input | 1 | A qualified write is present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| load_end | input | 1 | The page load in progress has finished |
| wr_permit | output | 1 | The current write may be stored |
| prot_on | output | 1 | Protection flag |
| win_open | output | 1 | A page-load window is open |
| lock_done | output | 1 | A permitted page load finished and the block re-locks |

## Verification
The hardest situation to reach is a sequence that breaks part-way through and restarts on the breaking write itself. One example is a repeated 0xAA@0x1555 after the first step. Another is a wrong data code after the second step, which must not be mistaken for the branch point between unlock and disable. The stimulus runs these broken sequences while protected and checks that every write in them is refused. It then finishes a restarted sequence and confirms that a window opens. A second hard case is a full window: the stimulus loads exactly PAGE_BYTES bytes, including one that looks like a command, and checks that the next byte is refused.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] K_LEAD   = 8'hAA;
  localparam logic [DATA_W-1:0] K_SECOND = 8'h55;
  localparam logic [DATA_W-1:0] K_UNLOCK = 8'hA0;
  localparam logic [DATA_W-1:0] K_ERASE  = 8'h80;
  localparam logic [DATA_W-1:0] K_CLEAR  = 8'h20;

  typedef enum logic [2:0] {
    M_IDLE = 3'd0,
    M_S1   = 3'd1,
    M_S2   = 3'd2,
    M_D3   = 3'd3,
    M_D4   = 3'd4,
    M_D5   = 3'd5
  } mstate_t;

  function automatic logic step_hit(input logic [31:0] addr, input logic [DATA_W-1:0] data,
                                    input logic [31:0] want_addr, input logic [DATA_W-1:0] want_data);
    return (addr == want_addr) && (data == want_data);
  endfunction
endpackage

// File: rtl/wp_seq_matcher.sv
module wp_seq_matcher
  import wp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] ADDR_HI = 13'h1555,
  parameter logic [ADDR_W-1:0] ADDR_LO = 13'h0AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              take,
  output logic              unlock_hit,
  output logic              disable_hit,
  output logic              idle
);
  mstate_t st_q, st_d;
  logic [31:0] a32, hi32, lo32;
  logic lead, second;

  assign a32    = 32'(addr);
  assign hi32   = 32'(ADDR_HI);
  assign lo32   = 32'(ADDR_LO);
  assign lead   = step_hit(a32, data, hi32, K_LEAD);
  assign second = step_hit(a32, data, lo32, K_SECOND);

  always_comb begin
    st_d        = st_q;
    take        = 1'b0;
    unlock_hit  = 1'b0;
    disable_hit = 1'b0;
    if (req) begin
      st_d = M_IDLE;
      unique case (st_q)
        M_IDLE: if (lead) begin st_d = M_S1; take = 1'b1; end
        M_S1: begin
          if (second)    begin st_d = M_S2; take = 1'b1; end
          else if (lead) begin st_d = M_S1; take = 1'b1; end
        end
        M_S2: begin
          if (step_hit(a32, data, hi32, K_UNLOCK)) begin take = 1'b1; unlock_hit = 1'b1; end
          else if (step_hit(a32, data, hi32, K_ERASE)) begin st_d = M_D3; take = 1'b1; end
          else if (lead) begin st_d = M_S1; take = 1'b1; end
        end
        M_D3: if (lead) begin st_d = M_D4; take = 1'b1; end
        M_D4: begin
          if (second)    begin st_d = M_D5; take = 1'b1; end
          else if (lead) begin st_d = M_S1; take = 1'b1; end
        end
        M_D5: begin
          if (step_hit(a32, data, hi32, K_CLEAR)) begin take = 1'b1; disable_hit = 1'b1; end
          else if (lead) begin st_d = M_S1; take = 1'b1; end
        end
        default: st_d = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= M_IDLE;
    else        st_q <= st_d;
  end

  assign idle = (st_q == M_IDLE);

  // R9: cycles without a write leave the matcher where it was
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(st_q));
  // R3/R8: a completed sequence leaves the matcher idle
  a_r3_idle_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_hit || disable_hit) |=> idle);
  a_r4_hit_is_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_hit || disable_hit) |-> take);
endmodule

// File: rtl/wp_page_window.sv
module wp_page_window #(
  parameter int PAGE_BYTES = 64,
  localparam int CNT_W = $clog2(PAGE_BYTES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic load_end,
  input  logic data_wr,
  output logic win_open,
  output logic room,
  output logic lock_done
);
  logic             win_q;
  logic [CNT_W-1:0] cnt_q;

  assign room      = cnt_q < CNT_W'(PAGE_BYTES);
  assign lock_done = win_q & load_end;
  assign win_open  = win_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      cnt_q <= '0;
    end else if (open_req) begin
      win_q <= 1'b1;
      cnt_q <= '0;
    end else if (lock_done) begin
      win_q <= 1'b0;
    end else if (win_q && data_wr && room) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6: the byte count never exceeds a page
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(PAGE_BYTES));
  // R7: a finished load closes the window
  a_r7_close_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    lock_done && !open_req |=> !win_q);
endmodule

// File: rtl/wp_cmd_guard.sv
module wp_cmd_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_BYTES = 64,
  parameter logic [ADDR_W-1:0] ADDR_HI = 13'h1555,
  parameter logic [ADDR_W-1:0] ADDR_LO = 13'h0AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_init,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_end,
  output logic              wr_permit,
  output logic              prot_on,
  output logic              win_open,
  output logic              lock_done
);
  logic match_req, cmd_take, unlock_hit, disable_hit, m_idle;
  logic room, data_wr, prot_q;

  assign match_req = wr_valid & ~win_open;

  wp_seq_matcher #(.ADDR_W(ADDR_W), .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)) u_match (
    .clk(clk), .rst_n(rst_n), .req(match_req), .addr(wr_addr), .data(wr_data),
    .take(cmd_take), .unlock_hit(unlock_hit), .disable_hit(disable_hit), .idle(m_idle)
  );

  assign data_wr = wr_valid & ~cmd_take;

  wp_page_window #(.PAGE_BYTES(PAGE_BYTES)) u_win (
    .clk(clk), .rst_n(rst_n), .open_req(unlock_hit), .load_end(load_end),
    .data_wr(data_wr), .win_open(win_open), .room(room), .lock_done(lock_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           prot_q <= prot_init;
    else if (unlock_hit)  prot_q <= 1'b1;
    else if (disable_hit) prot_q <= 1'b0;
  end

  assign prot_on   = prot_q;
  assign wr_permit = data_wr & (~prot_q | (win_open & room));

  // R3: unlock sets protection and opens the window
  a_r3_unlock_effect: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_hit |=> prot_on && win_open);
  // R8: disable clears protection
  a_r8_disable_effect: assert property (@(posedge clk) disable iff (!rst_n)
    disable_hit |=> !prot_on);
  // R4: command steps never reach the array
  a_r4_cmd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |-> !wr_permit);
  // R5: protected with no window means nothing is stored
  a_r5_locked_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    prot_on && !win_open |-> !wr_permit);
  // R7: closing a window leaves protection on
  a_r7_stay_locked: assert property (@(posedge clk) disable iff (!rst_n)
    lock_done |=> prot_on);
  // R6: the matcher does not move while a window is open
  a_r6_window_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> !cmd_take);
  // R1: the matcher sits idle right after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> m_idle && !win_open);
endmodule

// File: tb/wp_cmd_guard_bench.sv
module wp_cmd_guard_bench;
  localparam int AW = 13;
  localparam int PB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prot_init = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic load_end = 1'b0;
  logic wr_permit, prot_on, win_open, lock_done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  wp_cmd_guard #(.ADDR_W(AW), .PAGE_BYTES(PB)) u_wp_cmd_guard (
    .clk(clk), .rst_n(rst_n), .prot_init(prot_init), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .load_end(load_end),
    .wr_permit(wr_permit), .prot_on(prot_on), .win_open(win_open), .lock_done(lock_done)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected permit for every write it sees
  always @(negedge clk) begin
    #1;
    if (wr_valid) begin
      if (exp_q.size() == 0) check("monitor queue underflow", 1'b1, 1'b0);
      else check(tag_q.pop_front(), wr_permit, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input bit exp, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic peek();
    @(negedge clk); #1.5;
  endtask

  task automatic do_reset(input logic init);
    @(negedge clk);
    rst_n = 1'b0; prot_init = init;
    repeat (2) @(negedge clk);
    #1;
    check("R1 prot_on during reset", prot_on, init);
    rst_n = 1'b1;
    peek();
    check("R1 prot_on after reset", prot_on, init);
    check("R1 window closed after reset", win_open, 1'b0);
  endtask

  task automatic unlock(input bit permit_exp, input string tag);
    wr(13'h1555, 8'hAA, 1'b0, {tag, " R4 step1"});
    wr(13'h0AAA, 8'h55, 1'b0, {tag, " R4 step2"});
    wr(13'h1555, 8'hA0, 1'b0, {tag, " R4 step3"});
    peek();
    check({tag, " R3 prot_on set"}, prot_on, 1'b1);
    check({tag, " R3 window open"}, win_open, permit_exp);
  endtask

  task automatic finish_load(input string tag);
    @(negedge clk); load_end = 1'b1; #1;
    check({tag, " R7 lock_done pulse"}, lock_done, 1'b1);
    @(negedge clk); load_end = 1'b0; #1;
    check({tag, " R7 window closed"}, win_open, 1'b0);
    check({tag, " R7 protection stays"}, prot_on, 1'b1);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    // R2: unprotected writes pass
    wr(13'h0100, 8'h12, 1'b1, "R2 open write");
    wr(13'h1FFF, 8'hA0, 1'b1, "R2 open write code-like");
    // R9 while unprotected: broken step then ordinary write passes
    wr(13'h1555, 8'hAA, 1'b0, "R4 lone lead step");
    wr(13'h0200, 8'h34, 1'b1, "R9 breaker unprotected passes");
    // R3 from unprotected
    unlock(1'b1, "first unlock");
    wr(13'h0040, 8'h01, 1'b1, "R6 window byte 1");
    wr(13'h0041, 8'h02, 1'b1, "R6 window byte 2");
    finish_load("first load");
    // R5 locked
    wr(13'h0300, 8'h33, 1'b0, "R5 locked write");
    // R7 load_end with window closed
    @(negedge clk); load_end = 1'b1; #1;
    check("R7 no pulse when closed", lock_done, 1'b0);
    @(negedge clk); load_end = 1'b0;
    // R9 interrupted sequence
    wr(13'h1555, 8'hAA, 1'b0, "R9 step1");
    wr(13'h0300, 8'h77, 1'b0, "R9 breaker locked");
    wr(13'h0AAA, 8'h55, 1'b0, "R9 orphan step2");
    wr(13'h1555, 8'hA0, 1'b0, "R9 orphan step3");
    peek();
    check("R9 no window after break", win_open, 1'b0);
    // R9 wrong code at branch point
    wr(13'h1555, 8'hAA, 1'b0, "R9 b step1");
    wr(13'h0AAA, 8'h55, 1'b0, "R9 b step2");
    wr(13'h1555, 8'h90, 1'b0, "R9 wrong code");
    wr(13'h0400, 8'h11, 1'b0, "R9 after wrong code");
    peek();
    check("R9 no window after wrong code", win_open, 1'b0);
    // R9 restart on repeated lead
    wr(13'h1555, 8'hAA, 1'b0, "R9 lead");
    unlock(1'b1, "restart unlock");
    // R6 fill page, command-like byte is data inside window
    wr(13'h1555, 8'hAA, 1'b1, "R6 command-like data in window");
    for (int i = 1; i < PB; i++) wr(AW'(i), 8'(i), 1'b1, "R6 page fill");
    wr(13'h0500, 8'hEE, 1'b0, "R6 byte beyond page");
    finish_load("full load");
    // R8 disable
    wr(13'h1555, 8'hAA, 1'b0, "R8 d1");
    wr(13'h0AAA, 8'h55, 1'b0, "R8 d2");
    wr(13'h1555, 8'h80, 1'b0, "R8 d3");
    wr(13'h1555, 8'hAA, 1'b0, "R8 d4");
    wr(13'h0AAA, 8'h55, 1'b0, "R8 d5");
    peek();
    check("R8 still protected before sixth", prot_on, 1'b1);
    wr(13'h1555, 8'h20, 1'b0, "R8 d6");
    peek();
    check("R8 protection cleared", prot_on, 1'b0);
    wr(13'h0600, 8'h5A, 1'b1, "R2 write after disable");
    // R1 reset with stored protection
    do_reset(1'b1);
    wr(13'h0700, 8'h66, 1'b0, "R5 locked from reset");
    unlock(1'b1, "unlock when already on");
    wr(13'h0701, 8'h67, 1'b1, "R6 window byte after re-unlock");
    finish_load("last load");
    wait (exp_q.size() == 0);
    peek();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule